// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a single shift register of the most recent resolved outcomes, shared by every branch. To predict a branch, it joins that history with a few low bits of the branch address to select one entry in a table of 2-bit saturating counters. The high bit of the selected counter gives the prediction.

The fetch side presents a branch address with a lookup strobe. One cycle later it receives the prediction, together with the history value that was used to make it. When the branch resolves, the back end presents the address, the outcome and that same history value. The addressed counter moves one step toward the outcome, and the shared history shifts the outcome in. Because the caller returns the history with each update, the counter trained is the counter that made the prediction, even if other updates arrive in between.

The history length, the number of address bits and the instruction alignment are all parameters. The table depth follows from them as 2^(history bits + address bits).

Top module: `gh_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the history register holds zero. A lookup of any address then returns not taken with a reported history of zero.
- R2: A lookup strobe in one cycle gives `pred_valid` high in the next cycle. A cycle without a strobe gives `pred_valid` low in the next cycle.
- R3: Each update shifts the history left by one place, and the resolved outcome (1 = taken) enters bit 0. Without an update the history holds its value.
- R4: The table index is the history in the upper bits followed by address bits [ALIGN_W+PCIDX_W-1:ALIGN_W] in the lower bits. Address bits below ALIGN_W and above that field do not change the entry selected.
- R5: A taken update raises the addressed counter by one and leaves it at 3 when it is already 3.
- R6: A not-taken update lowers the addressed counter by one and leaves it at 0 when it is already 0.
- R7: The prediction is taken exactly when the selected counter is 2 or 3.
- R8: An update selects its counter using the history supplied with the update (`upd_hist`), not the current contents of the history register.
- R9: When a lookup and an update arrive in the same cycle, the lookup sees the counter value and the history from before that update.
- R10: The same address paired with different histories selects independent counters. Training one entry leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup strobe |
| lk_pc | input | ADDR_W | Address of the branch being looked up |
| pred_valid | output | 1 | A prediction is present (one cycle after the strobe) |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History used for this prediction, to be returned with the update |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | HIST_W | History that was used when this branch was predicted |

## Verification
The embedded properties assume the reset is held low until inputs settle. They also assume that a lookup and an update in the same cycle behave as two independent ports, and that `upd_hist` may hold any value. The history properties need HIST_W of at least 2.

The stimulus changes inputs only on falling edges and raises each strobe for exactly one rising edge. It steers the shared history to a chosen value by issuing updates on a scratch address and history that the scenarios never use for their own checks. This lets each counter be probed under a known history without reaching into the table.

// File: rtl/gh_pkg.sv
package gh_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MAX  = 2'd3;
  localparam ctr_t CTR_MIN  = 2'd0;
  localparam ctr_t CTR_INIT = 2'd1;

  // One saturating step toward the resolved outcome.
  function automatic ctr_t ctr_next(input ctr_t c, input logic taken);
    if (taken) return (c == CTR_MAX) ? c : ctr_t'(c + 2'd1);
    return (c == CTR_MIN) ? c : ctr_t'(c - 2'd1);
  endfunction

  // The upper half of the counter range predicts taken.
  function automatic logic ctr_taken(input ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/gh_index.sv
module gh_index #(
  parameter int ADDR_W  = 32,
  parameter int HIST_W  = 4,
  parameter int PCIDX_W = 6,
  parameter int ALIGN_W = 2,
  localparam int IDX_W  = HIST_W + PCIDX_W
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  // Only a slice of the address selects an entry; the rest is consumed here.
  logic idx_unused_pc;
  assign idx_unused_pc = ^pc;

  assign idx = {hist, pc[ALIGN_W +: PCIDX_W]};
endmodule

// File: rtl/gh_history.sv
module gh_history #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_in,
  output logic [HIST_W-1:0] ghr
);
  logic [HIST_W-1:0] ghr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ghr_q <= '0;
    else if (shift_en) ghr_q <= {ghr_q[HIST_W-2:0], shift_in};
  end

  assign ghr = ghr_q;

  assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> ghr_q == {$past(ghr_q[HIST_W-2:0]), $past(shift_in)});

  assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(ghr_q));
endmodule

// File: rtl/gh_counter_table.sv
module gh_counter_table
  import gh_pkg::*;
#(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_cnt,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  ctr_t tbl_q [DEPTH];
  ctr_t wr_old_cnt;
  ctr_t wr_new_cnt;

  assign rd_cnt     = tbl_q[rd_idx];
  assign wr_old_cnt = tbl_q[wr_idx];
  assign wr_new_cnt = ctr_next(wr_old_cnt, wr_taken);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= wr_new_cnt;
    end
  end

  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old_cnt != CTR_MAX)
      |=> tbl_q[$past(wr_idx)] == ctr_t'($past(wr_old_cnt) + 2'd1));

  assert_sat_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old_cnt == CTR_MAX) |=> tbl_q[$past(wr_idx)] == CTR_MAX);

  assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old_cnt != CTR_MIN)
      |=> tbl_q[$past(wr_idx)] == ctr_t'($past(wr_old_cnt) - 2'd1));

  assert_sat_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old_cnt == CTR_MIN) |=> tbl_q[$past(wr_idx)] == CTR_MIN);
endmodule

// File: rtl/gh_predictor.sv
module gh_predictor
  import gh_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int HIST_W  = 4,
  parameter int PCIDX_W = 6,
  parameter int ALIGN_W = 2,
  localparam int IDX_W  = HIST_W + PCIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);
  logic [HIST_W-1:0] ghr;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  upd_idx;
  ctr_t              lk_cnt;

  gh_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .shift_en(upd_valid), .shift_in(upd_taken), .ghr(ghr)
  );

  gh_index #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PCIDX_W(PCIDX_W), .ALIGN_W(ALIGN_W)) u_lk_idx (
    .pc(lk_pc), .hist(ghr), .idx(lk_idx)
  );

  gh_index #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PCIDX_W(PCIDX_W), .ALIGN_W(ALIGN_W)) u_upd_idx (
    .pc(upd_pc), .hist(upd_hist), .idx(upd_idx)
  );

  gh_counter_table #(.IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_cnt(lk_cnt),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_taken <= 1'b0;
      pred_hist  <= '0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) begin
        pred_taken <= ctr_taken(lk_cnt);
        pred_hist  <= ghr;
      end
    end
  end

  assert_pred_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_valid);

  assert_pred_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !pred_valid);

  assert_pred_thresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_taken == ($past(lk_cnt) >= 2'd2));

  assert_pred_hist_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pred_hist == $past(ghr));
endmodule

// File: tb/tb_gh_predictor.sv
`timescale 1ns/1ps
module tb_gh_predictor;
  localparam int ADDR_W  = 32;
  localparam int HIST_W  = 4;
  localparam int PCIDX_W = 6;
  localparam int ALIGN_W = 2;
  localparam int DEPTH   = 1 << (HIST_W + PCIDX_W);
  localparam logic [ADDR_W-1:0] SCR_PC = 32'h0000_00FC; // entry field 63
  localparam logic [HIST_W-1:0] SCR_H  = 4'hF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_pc = '0;
  logic pred_valid, pred_taken;
  logic [HIST_W-1:0] pred_hist;
  logic upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_pc = '0;
  logic upd_taken = 1'b0;
  logic [HIST_W-1:0] upd_hist = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0] m_cnt [DEPTH];
  logic [HIST_W-1:0] m_hist;

  always #2 clk = ~clk;

  gh_predictor #(.ADDR_W(ADDR_W), .HIST_W(HIST_W), .PCIDX_W(PCIDX_W), .ALIGN_W(ALIGN_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  function automatic int m_index(logic [ADDR_W-1:0] pc, logic [HIST_W-1:0] h);
    return int'(h) * (1 << PCIDX_W) + int'((pc >> ALIGN_W) & ((1 << PCIDX_W) - 1));
  endfunction

  task automatic m_apply(logic [ADDR_W-1:0] pc, logic tk, logic [HIST_W-1:0] h);
    int i = m_index(pc, h);
    if (tk && m_cnt[i] < 2'd3) m_cnt[i] = m_cnt[i] + 2'd1;
    else if (!tk && m_cnt[i] > 2'd0) m_cnt[i] = m_cnt[i] - 2'd1;
    m_hist = HIST_W'({m_hist, tk});
  endtask

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic do_update(logic [ADDR_W-1:0] pc, logic tk, logic [HIST_W-1:0] h);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_hist = h;
    @(negedge clk);
    upd_valid = 1'b0;
    m_apply(pc, tk, h);
  endtask

  task automatic do_lookup(logic [ADDR_W-1:0] pc, string req, output logic got);
    logic exp_t;
    logic [HIST_W-1:0] exp_h;
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc;
    exp_t = (m_cnt[m_index(pc, m_hist)] >= 2'd2);
    exp_h = m_hist;
    @(negedge clk);
    check("R2", "pred_valid", int'(pred_valid), 1);
    check(req, "pred_taken", int'(pred_taken), int'(exp_t));
    check(req, "pred_hist", int'(pred_hist), int'(exp_h));
    got = pred_taken;
    lk_valid = 1'b0;
  endtask

  task automatic set_ghr(logic [HIST_W-1:0] v);
    for (int b = HIST_W - 1; b >= 0; b--) do_update(SCR_PC, v[b], SCR_H);
  endtask

  task automatic probe(logic [ADDR_W-1:0] pc, logic [HIST_W-1:0] h, string req, int lit);
    logic got;
    set_ghr(h);
    do_lookup(pc, req, got);
    check(req, "literal prediction", int'(got), lit);
  endtask

  task automatic t_reset();
    logic got;
    check("R2", "pred_valid idle after reset", int'(pred_valid), 0);
    do_lookup(32'h0000_0000, "R1", got);
    check("R1", "reset prediction", int'(got), 0);
    check("R1", "reset history", int'(pred_hist), 0);
    do_lookup(32'h1234_51F4, "R1", got);
    check("R1", "reset prediction other pc", int'(got), 0);
  endtask

  task automatic t_valid_strobe();
    logic got;
    do_lookup(32'h0000_0010, "R2", got);
    @(negedge clk);
    check("R2", "pred_valid drops without strobe", int'(pred_valid), 0);
  endtask

  task automatic t_history();
    logic got;
    do_update(SCR_PC, 1'b1, SCR_H);
    do_update(SCR_PC, 1'b0, SCR_H);
    do_update(SCR_PC, 1'b1, SCR_H);
    do_update(SCR_PC, 1'b1, SCR_H);
    do_lookup(32'h0000_0004, "R3", got);
    check("R3", "history after 1011", int'(pred_hist), 4'b1011);
    do_update(SCR_PC, 1'b1, SCR_H);
    do_lookup(32'h0000_0004, "R3", got);
    check("R3", "history after further taken", int'(pred_hist), 4'b0111);
  endtask

  task automatic t_sat_up();
    logic [ADDR_W-1:0] pc = 32'h0000_0040;
    do_update(pc, 1'b1, 4'h0);
    probe(pc, 4'h0, "R7", 1);
    do_update(pc, 1'b1, 4'h0);
    do_update(pc, 1'b1, 4'h0);
    do_update(pc, 1'b1, 4'h0);
    do_update(pc, 1'b0, 4'h0);
    probe(pc, 4'h0, "R5", 1);
    do_update(pc, 1'b0, 4'h0);
    probe(pc, 4'h0, "R5", 0);
  endtask

  task automatic t_sat_down();
    logic [ADDR_W-1:0] pc = 32'h0000_0080;
    do_update(pc, 1'b0, 4'h3);
    do_update(pc, 1'b0, 4'h3);
    do_update(pc, 1'b0, 4'h3);
    do_update(pc, 1'b1, 4'h3);
    probe(pc, 4'h3, "R6", 0);
    do_update(pc, 1'b1, 4'h3);
    probe(pc, 4'h3, "R6", 1);
  endtask

  task automatic t_index_bits();
    do_update(32'h0000_00C0, 1'b1, 4'h5);
    do_update(32'h0000_00C0, 1'b1, 4'h5);
    probe(32'hABCD_E0C3, 4'h5, "R4", 1);
    probe(32'h0000_00C4, 4'h5, "R4", 0);
    probe(32'h0000_00C0, 4'h4, "R4", 0);
  endtask

  task automatic t_update_hist();
    set_ghr(4'h2);
    do_update(32'h0000_0104, 1'b1, 4'h9);
    do_update(32'h0000_0104, 1'b1, 4'h9);
    probe(32'h0000_0104, 4'h9, "R8", 1);
    probe(32'h0000_0104, 4'h2, "R8", 0);
    probe(32'h0000_0104, 4'h5, "R8", 0);
  endtask

  task automatic t_isolation();
    do_update(32'h0000_0020, 1'b1, 4'hC);
    do_update(32'h0000_0020, 1'b1, 4'hC);
    probe(32'h0000_0020, 4'hC, "R10", 1);
    probe(32'h0000_0020, 4'hD, "R10", 0);
    probe(32'h0000_0020, 4'h4, "R10", 0);
  endtask

  task automatic t_same_cycle();
    set_ghr(4'h7);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = 32'h0000_0030;
    upd_valid = 1'b1; upd_pc = 32'h0000_0030; upd_taken = 1'b1; upd_hist = 4'h7;
    @(negedge clk);
    check("R9", "same-cycle prediction uses old counter", int'(pred_taken), 0);
    check("R9", "same-cycle history is pre-update", int'(pred_hist), 7);
    lk_valid = 1'b0; upd_valid = 1'b0;
    m_apply(32'h0000_0030, 1'b1, 4'h7);
    probe(32'h0000_0030, 4'h7, "R9", 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_cnt[i] = 2'd1;
    m_hist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_valid_strobe();
    t_history();
    t_sat_up();
    t_sat_down();
    t_index_bits();
    t_update_hist();
    t_isolation();
    t_same_cycle();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule